// File: doc/BRIEF.md
# Clock-Synchronous Serial Master with Flow Control

This block is a full-duplex serial channel that drives its own bit clock. Software loads bytes into a one-entry holding register. When the shifter is free and the far end is ready, the holding register moves into the shifter. Each frame shifts 8 bits out on the data output and, at the same time, shifts 8 bits in from the data input. A received frame lands in a receive holding register. Two level outputs request service: one when the transmit holding register empties, one when a byte has arrived.

The bit clock comes from a source selector followed by a divide-by-2(m+1) stage. The source is the core clock, the core clock divided by 8, or the core clock divided by 2n. The far end holds transmission back with an active-low ready input, which passes through a two-flop synchronizer. Clearing the enable bit lets the frame in flight finish and starts no new one.

Top module: `sync_serial_xcvr`

## Requirements
- R1: With the undivided source, the bit clock period is 2(m+1) core cycles, where m is the 8-bit value at address 2; each half period lasts m+1 source ticks.
- R2: Address 3 bits [1:0] pick the source: 0 is the core clock, 1 is core/8, 2 is core/(2n). The value n is in bits [7:4], and n = 0 means undivided.
- R3: A frame is 8 bits, least significant first. The data output changes on the falling edge of the serial clock, and the data input is sampled on the rising edge.
- R4: Writing address 0 fills the transmit holding register; status bit 1 (holding empty) reads 0 until the byte moves to the shifter. The move sets status bit 1, status bit 5 and tx_irq_o. Bytes written back to back go out in write order.
- R5: No frame starts while cts_ni is high, after two-flop synchronization. A waiting byte starts once cts_ni is low.
- R6: Writing 0 to address 1 bit 0 (enable) lets the current frame finish and starts no further frame. The serial clock idles high and the data output idles high outside frames.
- R7: Status bit 2 (transmitter empty) is 1 only when both the holding register and the shifter are empty.
- R8: At the end of each frame, the received byte is readable at address 0, and status bit 3 (receive full), status bit 6 and rx_irq_o are set one cycle after the last rising edge.
- R9: A read of address 0 clears receive full. tx_ack_i and rx_ack_i clear their requests. Writing 1 to address 1 bit 5 or bit 6 also clears the matching request.
- R10: A frame that ends while receive full is set overwrites the receive register and sets status bit 4 (overrun). Writing 1 to address 1 bit 4 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe (side effect on address 0) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| tx_ack_i | input | 1 | Clears transmit request |
| rx_ack_i | input | 1 | Clears receive request |
| tx_irq_o | output | 1 | Transmit holding register emptied |
| rx_irq_o | output | 1 | Byte received |
| sclk_o | output | 1 | Serial clock, idles high |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| cts_ni | input | 1 | Far end ready, active low |

## Verification
Register effects appear on the first clock edge after a strobe, so the bench reads status one cycle after any write. A byte placed in an idle transmitter starts on the next edge. Its first falling serial edge comes (m+1) source ticks later. The flags for a finished frame appear one edge after the last rising serial edge. The bench acts as the far end: it drives the input bit on each observed falling edge and captures the output bit there. It measures the bit period between the first two falling edges of every frame. Before it reads flags or data, it waits a full bit period plus a margin after the eighth falling edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    SRC_DIRECT = 2'd0,
    SRC_DIV8   = 2'd1,
    SRC_DIV2N  = 2'd2
  } src_sel_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_SRC  = 2'd3;

  localparam int ST_EN      = 0;
  localparam int ST_TB_EMPT = 1;
  localparam int ST_TX_EMPT = 2;
  localparam int ST_RX_FULL = 3;
  localparam int ST_OVR     = 4;
  localparam int ST_TX_IRQ  = 5;
  localparam int ST_RX_IRQ  = 6;
endpackage

// File: rtl/sio_prescaler.sv
module sio_prescaler
  import sio_pkg::*;
#(
  parameter int N_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  src_sel_e       sel_i,
  input  logic [N_W-1:0] n_i,
  output logic           tick_o
);
  localparam int PW = (N_W + 1 > 3) ? N_W + 1 : 3;

  logic [PW-1:0] cnt_q, lim;

  always_comb begin
    case (sel_i)
      SRC_DIV8:  lim = PW'(7);
      SRC_DIV2N: lim = (n_i == '0) ? '0 : PW'({n_i, 1'b0}) - PW'(1);
      default:   lim = '0;
    endcase
  end

  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tick_o ? '0 : cnt_q + PW'(1);
  end

  // R2: the divide-by-8 source never ticks on two cycles in a row
  a_r2_div8_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SRC_DIV8 && $past(sel_i) == SRC_DIV8 && $past(tick_o)) |-> !tick_o);
endmodule

// File: rtl/sio_cts_sync.sv
module sio_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[i] <= 1'b1;  // reset as "not ready"
      else if (i == 0) sr_q[i] <= d_i;
      else sr_q[i] <= sr_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sio_engine.sv
module sio_engine #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DIV_W-1:0]  div_m_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rxd_i,
  output logic              sclk_o,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DIV_W-1:0]  dcnt_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [DATA_W-1:0] tsr_q, rsr_q;
  logic              half;

  assign half      = busy_o && tick_i && (dcnt_q == div_m_i);
  assign rx_data_o = rsr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q <= '0;
      bcnt_q <= '0;
      tsr_q  <= '0;
      rsr_q  <= '0;
      sclk_o <= 1'b1;
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        tsr_q  <= load_data_i;
        dcnt_q <= '0;
        bcnt_q <= '0;
      end else if (busy_o && tick_i) begin
        if (half) begin
          dcnt_q <= '0;
          if (sclk_o) begin
            // falling edge: present next bit
            sclk_o <= 1'b0;
            txd_o  <= tsr_q[0];
            tsr_q  <= {1'b0, tsr_q[DATA_W-1:1]};
          end else begin
            // rising edge: sample input
            sclk_o <= 1'b1;
            rsr_q  <= {rxd_i, rsr_q[DATA_W-1:1]};
            bcnt_q <= bcnt_q + CNT_W'(1);
            if (bcnt_q == CNT_W'(DATA_W-1)) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              txd_o  <= 1'b1;
            end
          end
        end else begin
          dcnt_q <= dcnt_q + DIV_W'(1);
        end
      end
    end
  end

  // R3: output bit only moves when the serial clock is falling or low
  a_r3_txd_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(txd_o));
  // R1: serial clock toggles only on a source tick
  a_r1_toggle_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> $past(tick_i));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int N_W    = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic        bus_re_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  input  logic        tx_ack_i,
  input  logic        rx_ack_i,
  output logic        tx_irq_o,
  output logic        rx_irq_o,
  output logic        sclk_o,
  output logic        txd_o,
  input  logic        rxd_i,
  input  logic        cts_ni
);
  logic [DATA_W-1:0] tbuf_q, rbuf_q, eng_rx;
  logic [DIV_W-1:0]  div_m_q;
  logic [1:0]        src_q;
  logic [N_W-1:0]    n_q;
  logic tbuf_full_q, tx_en_q, rx_full_q, ovr_q;
  logic tick, start, busy, done, cts_q;
  logic tb_wr, rb_rd, ctrl_wr;

  assign tb_wr   = bus_we_i && bus_addr_i == ADDR_DATA;
  assign ctrl_wr = bus_we_i && bus_addr_i == ADDR_CTRL;
  assign rb_rd   = bus_re_i && bus_addr_i == ADDR_DATA;
  assign start   = tx_en_q && tbuf_full_q && !cts_q && !busy;

  sio_cts_sync #(.STAGES(2)) u_cts (
    .clk_i, .rst_ni, .d_i(cts_ni), .q_o(cts_q)
  );

  sio_prescaler #(.N_W(N_W)) u_pre (
    .clk_i, .rst_ni, .sel_i(src_sel_e'(src_q)), .n_i(n_q), .tick_o(tick)
  );

  sio_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_eng (
    .clk_i, .rst_ni, .tick_i(tick), .div_m_i(div_m_q), .start_i(start),
    .load_data_i(tbuf_q), .rxd_i, .sclk_o, .txd_o, .busy_o(busy),
    .done_o(done), .rx_data_o(eng_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbuf_q      <= '0;
      tbuf_full_q <= 1'b0;
      tx_en_q     <= 1'b0;
      div_m_q     <= '0;
      src_q       <= '0;
      n_q         <= '0;
    end else begin
      if (start) tbuf_full_q <= 1'b0;
      if (tb_wr) begin
        tbuf_q      <= DATA_W'(bus_wdata_i);
        tbuf_full_q <= 1'b1;
      end
      if (ctrl_wr) tx_en_q <= bus_wdata_i[ST_EN];
      if (bus_we_i && bus_addr_i == ADDR_DIV) div_m_q <= DIV_W'(bus_wdata_i);
      if (bus_we_i && bus_addr_i == ADDR_SRC) begin
        src_q <= bus_wdata_i[1:0];
        n_q   <= N_W'(bus_wdata_i[7:4]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q    <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      tx_irq_o  <= 1'b0;
      rx_irq_o  <= 1'b0;
    end else begin
      if (done) begin
        rbuf_q    <= eng_rx;
        rx_full_q <= 1'b1;
      end else if (rb_rd) begin
        rx_full_q <= 1'b0;
      end
      if (done && rx_full_q && !rb_rd)        ovr_q <= 1'b1;
      else if (ctrl_wr && bus_wdata_i[ST_OVR]) ovr_q <= 1'b0;
      if (start)                                                tx_irq_o <= 1'b1;
      else if (tx_ack_i || (ctrl_wr && bus_wdata_i[ST_TX_IRQ])) tx_irq_o <= 1'b0;
      if (done)                                                 rx_irq_o <= 1'b1;
      else if (rx_ack_i || (ctrl_wr && bus_wdata_i[ST_RX_IRQ])) rx_irq_o <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_DATA: bus_rdata_o = 8'(rbuf_q);
      ADDR_CTRL: begin
        bus_rdata_o[ST_EN]      = tx_en_q;
        bus_rdata_o[ST_TB_EMPT] = !tbuf_full_q;
        bus_rdata_o[ST_TX_EMPT] = !tbuf_full_q && !busy;
        bus_rdata_o[ST_RX_FULL] = rx_full_q;
        bus_rdata_o[ST_OVR]     = ovr_q;
        bus_rdata_o[ST_TX_IRQ]  = tx_irq_o;
        bus_rdata_o[ST_RX_IRQ]  = rx_irq_o;
      end
      ADDR_DIV:  bus_rdata_o = 8'(div_m_q);
      default:   bus_rdata_o = {4'(n_q), 2'b00, src_q};
    endcase
  end

  // R5: a frame only begins with far end ready and enable set
  a_r5_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(!cts_q && tx_en_q));
  // R4: moving a byte to the shifter empties the holding register
  a_r4_load_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !tb_wr) |=> !tbuf_full_q);
  // R8: end of frame raises receive full and its request
  a_r8_done_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (rx_full_q && rx_irq_o));
  // R6: serial clock idles high between frames
  a_r6_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sclk_o);
  // R10: frame landing on an unread byte flags overrun
  a_r10_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full_q && !rb_rd) |=> ovr_q);
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_we = 0, bus_re = 0, tx_ack = 0, rx_ack = 0, rxd = 1, cts_n = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic tx_irq, rx_irq, sclk, txd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_xcvr u_sync_serial_xcvr (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_re_i(bus_re),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_ack_i(tx_ack), .rx_ack_i(rx_ack), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .sclk_o(sclk), .txd_o(txd), .rxd_i(rxd), .cts_ni(cts_n)
  );

  int checks = 0, errors = 0, cyc = 0, cur_half = 1;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // far-end model
  int frames = 0, bit_k = 0, fall0_t = 0, last_period = 0;
  logic [7:0] cap = 0, pat;
  logic [7:0] cap_log [64];
  logic prev_sclk = 1'b1;

  function automatic logic [7:0] slv_pat(int i);
    return 8'(32'h3C ^ (i * 37));
  endfunction

  function automatic int exp_period(int m, int sel, int n);
    int div;
    div = (sel == 1) ? 8 : ((sel == 2 && n != 0) ? 2 * n : 1);
    return 2 * (m + 1) * div;
  endfunction

  initial forever begin
    @(negedge clk);
    if (prev_sclk && !sclk) begin
      cap[bit_k] = txd;
      pat = slv_pat(frames);
      rxd = pat[bit_k];
      if (bit_k == 0) fall0_t = cyc;
      else if (bit_k == 1) last_period = cyc - fall0_t;
      if (bit_k == 7) begin
        cap_log[frames % 64] = cap;
        frames++;
        bit_k = 0;
      end else bit_k++;
    end
    prev_sclk = sclk;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 0;
  endtask

  task automatic cfg(int m, int sel, int n);
    bus_write(2'd2, 8'(m));
    bus_write(2'd3, {4'(n), 2'b00, 2'(sel)});
    cur_half = exp_period(m, sel, n) / 2;
  endtask

  task automatic wait_frames(int tgt, string req);
    int t = 0;
    while (frames < tgt && t < 30000) begin @(negedge clk); t++; end
    if (frames < tgt) chk(req, frames, tgt);
    repeat (2 * cur_half + 4) @(negedge clk);
  endtask

  logic [7:0] rd;

  initial begin
    int f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // reset state
    chk("R6 sclk idle", sclk, 1);
    chk("R6 txd idle", txd, 1);
    bus_read(2'd1, rd);
    chk("R7 reset status", rd, 8'h06);

    // basic frame, undivided source, m=2
    cfg(2, 0, 0);
    bus_write(2'd1, 8'h01);
    f = frames;
    bus_write(2'd0, 8'hA5);
    wait_frames(f + 1, "R3 frame A");
    chk("R3 lsb-first tx", cap_log[f % 64], 8'hA5);
    chk("R1 period m=2", last_period, 6);
    bus_read(2'd1, rd);
    chk("R8 status after frame", rd, 8'h6F);
    chk("R4 tx_irq", tx_irq, 1);
    chk("R8 rx_irq", rx_irq, 1);
    bus_read(2'd0, rd);
    chk("R8 rx data", rd, slv_pat(f));
    @(negedge clk); tx_ack = 1; @(negedge clk); tx_ack = 0;
    chk("R9 tx ack", tx_irq, 0);
    bus_write(2'd1, 8'h41);
    chk("R9 rx w1c", rx_irq, 0);
    bus_read(2'd1, rd);
    chk("R9 status cleared", rd, 8'h07);

    // back to back writes, overrun
    f = frames;
    bus_write(2'd0, 8'h11);
    bus_write(2'd0, 8'h22);
    bus_read(2'd1, rd);
    chk("R4 holding full", rd[1], 0);
    chk("R7 not empty", rd[2], 0);
    wait_frames(f + 2, "R4 two frames");
    chk("R4 order first", cap_log[f % 64], 8'h11);
    chk("R4 order second", cap_log[(f + 1) % 64], 8'h22);
    bus_read(2'd1, rd);
    chk("R10 overrun set", rd[4], 1);
    bus_read(2'd0, rd);
    chk("R10 rx overwritten", rd, slv_pat(f + 1));
    bus_write(2'd1, 8'h11);
    bus_read(2'd1, rd);
    chk("R10 overrun cleared", rd[4], 0);
    chk("R9 rx full cleared", rd[3], 0);

    // far end not ready
    cts_n = 1;
    repeat (4) @(negedge clk);
    f = frames;
    bus_write(2'd0, 8'h5A);
    repeat (60) @(negedge clk);
    chk("R5 held by cts", frames, f);
    chk("R5 sclk stays high", sclk, 1);
    bus_read(2'd1, rd);
    chk("R5 byte waiting", rd[1], 0);
    cts_n = 0;
    wait_frames(f + 1, "R5 resume");
    chk("R5 data after resume", cap_log[f % 64], 8'h5A);

    // disable mid frame
    f = frames;
    bus_write(2'd0, 8'hC3);
    while (bit_k == 0 && frames == f) @(negedge clk);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'h99);
    wait_frames(f + 1, "R6 frame finishes");
    chk("R6 current frame done", cap_log[f % 64], 8'hC3);
    repeat (40) @(negedge clk);
    chk("R6 no new frame", frames, f + 1);
    chk("R6 sclk idle", sclk, 1);
    chk("R6 txd idle", txd, 1);
    bus_write(2'd1, 8'h01);
    wait_frames(f + 2, "R6 re-enable");
    chk("R6 pending sent", cap_log[(f + 1) % 64], 8'h99);

    // source selection
    cfg(1, 1, 0);
    f = frames; bus_write(2'd0, 8'h3E); wait_frames(f + 1, "R2 div8");
    chk("R2 div8 period", last_period, 32);
    cfg(0, 2, 3);
    f = frames; bus_write(2'd0, 8'h81); wait_frames(f + 1, "R2 div2n");
    chk("R2 div6 period", last_period, 12);
    cfg(0, 2, 0);
    f = frames; bus_write(2'd0, 8'h7E); wait_frames(f + 1, "R2 n0");
    chk("R2 n=0 period", last_period, 2);
    chk("R3 data at min period", cap_log[f % 64], 8'h7E);

    // random frames
    for (int i = 0; i < 16; i++) begin
      int m, sel, n;
      logic [7:0] d;
      m = int'($urandom % 4);
      sel = int'($urandom % 3);
      n = int'($urandom % 4);
      d = 8'($urandom);
      cfg(m, sel, n);
      f = frames;
      bus_write(2'd0, d);
      wait_frames(f + 1, "R3 random");
      chk("R3 random tx", cap_log[f % 64], d);
      chk("R1 random period", last_period, exp_period(m, sel, n));
      bus_read(2'd0, rd);
      chk("R8 random rx", rd, slv_pat(f));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule